// File: doc/BRIEF.md
# Snapshot-Read 64-bit Cycle Counter

This block keeps a 64-bit cycle count that runs without stopping and lets software on a 32-bit register port read it without tearing. Software does not read the two halves of the live count. It first writes a capture command into the control word. One clock later the whole count is copied into a pair of held registers, which can then be read high word first and low word second. Both halves come from the same instant.

The same control word also reloads the counter. Software writes the two load registers and then issues the load command. The counter takes the preset value on the next clock and counts up from it. A divider field in the control word slows the count: a field value `d` advances the counter once every `d+1` clocks. Zero means one step per clock.

Commands are handled by a small state machine with three states. `CMD_IDLE` is the rest state. `CMD_CAPTURE` is entered from any state when a control write has bit 0 set and bit 1 clear. `CMD_LOAD` is entered from any state when a control write has bits 0 and 1 both set. From `CMD_CAPTURE` or `CMD_LOAD`, the machine goes back to `CMD_IDLE` on the next clock unless another command write arrives. In `CMD_CAPTURE` the held registers take the count. In `CMD_LOAD` the counter takes the load registers.

Top module: `snap_cycle_counter`

## Requirements
- R1: After reset, every register reads 0: control, live count, load and held registers.
- R2: A write to control (offset 0x68) with bit 0 = 1 and bit 1 = 0 puts the machine in `CMD_CAPTURE`. At the next clock edge, the held low (0x7C) and high (0x80) words take the live count present just before that edge.
- R3: A write to control with bits 0 and 1 both set puts the machine in `CMD_LOAD`. At the next clock edge, the live count takes {load high (0x78), load low (0x74)}. Counting then resumes upward from that value.
- R4: Control bits [1:0] read back the pending command (01 for capture, 11 for load) for the one cycle it is pending, and 00 after that. The divider field in control bits [15:8] keeps the value last written.
- R5: The held registers keep their value while the counter advances and during loads. They change only at a capture.
- R6: With divider field value d, the live count advances exactly once in every d+1 consecutive clocks. With d = 0 it advances every clock.
- R7: The live count runs over the full 64-bit range, read at 0x6C (low) and 0x70 (high), and wraps from all ones to 0.
- R8: Writes to the live-count and held-register offsets are ignored. A control write with bit 0 = 0 starts no command.
- R9: When a load and a count step fall on the same edge, the loaded value is stored without the step. The prescaler phase restarts from the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting and register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 8 | Byte offset for both the write and the read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |

## Verification
A wrong command state shows up in the control readback in the cycle right after the write. It also shows up one cycle later as held registers that change without a capture, or a count that jumps to the load value without a load. A prescaler phase error or a lost or doubled step shows in the live count within d+1 clocks. The bench keeps a behavioural model and compares the addressed register with it after every clock edge, so most faults are reported within a cycle of the first wrong edge. Wrap-around is tested by preloading a value two steps below 2^64.

// File: rtl/snapctr_pkg.sv
package snapctr_pkg;

    // Encoding equals the readback of control bits [1:0]
    typedef enum logic [1:0] {
        CMD_IDLE    = 2'b00,
        CMD_CAPTURE = 2'b01,
        CMD_LOAD    = 2'b11
    } cmd_state_t;

    localparam int OFS_CTRL   = 'h68;
    localparam int OFS_CNT_LO = 'h6C;
    localparam int OFS_CNT_HI = 'h70;
    localparam int OFS_LD_LO  = 'h74;
    localparam int OFS_LD_HI  = 'h78;
    localparam int OFS_HLD_LO = 'h7C;
    localparam int OFS_HLD_HI = 'h80;

endpackage

// File: rtl/snapctr_cmd_fsm.sv
module snapctr_cmd_fsm
    import snapctr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_cmd,
    input  logic       want_load,
    output cmd_state_t state_o,
    output logic       do_capture,
    output logic       do_load
);
    cmd_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CMD_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        if (start_cmd) state_d = want_load ? CMD_LOAD : CMD_CAPTURE;
        else           state_d = CMD_IDLE;
    end

    always_comb begin
        do_capture = 1'b0;
        do_load    = 1'b0;
        unique case (state_q)
            CMD_IDLE:    ;
            CMD_CAPTURE: do_capture = 1'b1;
            CMD_LOAD:    do_load    = 1'b1;
            default:     ;
        endcase
    end

    assign state_o = state_q;

    // R4: a pending command clears itself after one cycle
    a_r4_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != CMD_IDLE && !start_cmd) |=> state_q == CMD_IDLE);

    a_r2_capture_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (start_cmd && !want_load) |=> do_capture && !do_load);

endmodule

// File: rtl/snapctr_prescale.sv
module snapctr_prescale #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    input  logic             restart,
    output logic             tick
);
    logic [DIV_W-1:0] phase_q;

    assign tick = (phase_q >= div);

    always_ff @(posedge clk) begin
        if (!rst_n)                phase_q <= '0;
        else if (restart || tick)  phase_q <= '0;
        else                       phase_q <= phase_q + 1'b1;
    end

    // R6: after a step, the next step is at least d+1 clocks away unless d is 0
    a_r6_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (!tick || div == '0));

endmodule

// File: rtl/snap_cycle_counter.sv
module snap_cycle_counter
    import snapctr_pkg::*;
#(
    parameter int REG_W   = 32,
    parameter int ADDR_W  = 8,
    parameter int DIV_W   = 8,
    parameter int DIV_LSB = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata
);
    localparam int CNT_W = 2 * REG_W;

    logic [DIV_W-1:0] div_q;
    logic [REG_W-1:0] ld_lo_q, ld_hi_q;
    logic [CNT_W-1:0] cnt_q, held_q;
    logic             ctrl_wr, tick, do_capture, do_load;
    cmd_state_t       cmd_state;

    assign ctrl_wr = reg_wr && (reg_addr == ADDR_W'(OFS_CTRL));

    snapctr_cmd_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_cmd  (ctrl_wr && reg_wdata[0]),
        .want_load  (reg_wdata[1]),
        .state_o    (cmd_state),
        .do_capture (do_capture),
        .do_load    (do_load)
    );

    snapctr_prescale #(.DIV_W(DIV_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .div     (div_q),
        .restart (do_load),
        .tick    (tick)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q   <= '0;
            ld_lo_q <= '0;
            ld_hi_q <= '0;
        end else if (reg_wr) begin
            if (reg_addr == ADDR_W'(OFS_CTRL))  div_q   <= reg_wdata[DIV_LSB +: DIV_W];
            if (reg_addr == ADDR_W'(OFS_LD_LO)) ld_lo_q <= reg_wdata;
            if (reg_addr == ADDR_W'(OFS_LD_HI)) ld_hi_q <= reg_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (do_load) cnt_q <= {ld_hi_q, ld_lo_q};
        else if (tick)    cnt_q <= cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)          held_q <= '0;
        else if (do_capture) held_q <= cnt_q;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(OFS_CTRL)) begin
            reg_rdata[DIV_LSB +: DIV_W] = div_q;
            reg_rdata[1:0]              = cmd_state;
        end
        else if (reg_addr == ADDR_W'(OFS_CNT_LO)) reg_rdata = cnt_q[REG_W-1:0];
        else if (reg_addr == ADDR_W'(OFS_CNT_HI)) reg_rdata = cnt_q[CNT_W-1:REG_W];
        else if (reg_addr == ADDR_W'(OFS_LD_LO))  reg_rdata = ld_lo_q;
        else if (reg_addr == ADDR_W'(OFS_LD_HI))  reg_rdata = ld_hi_q;
        else if (reg_addr == ADDR_W'(OFS_HLD_LO)) reg_rdata = held_q[REG_W-1:0];
        else if (reg_addr == ADDR_W'(OFS_HLD_HI)) reg_rdata = held_q[CNT_W-1:REG_W];
    end

    // R2: a capture copies the pre-edge count
    a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
        do_capture |=> held_q == $past(cnt_q));

    // R3 / R9: a load stores the load registers without a step
    a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
        do_load |=> cnt_q == $past({ld_hi_q, ld_lo_q}));

    // R5: held words move only on a capture
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !do_capture |=> $stable(held_q));

    // R7: one step is +1 modulo 2^64
    a_r7_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !do_load) |=> cnt_q == $past(cnt_q) + CNT_W'(1));

    a_r6_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !do_load) |=> $stable(cnt_q));

endmodule

// File: tb/snap_cycle_counter_bench.sv
module snap_cycle_counter_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    snap_cycle_counter u_snap_cycle_counter (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    // Behavioural reference model
    logic [63:0] m_cnt, m_held;
    logic [31:0] m_ldlo, m_ldhi;
    logic [7:0]  m_div;
    logic [1:0]  m_pend;
    int          m_phase;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_held = 0; m_ldlo = 0; m_ldhi = 0;
            m_div = 0; m_pend = 0; m_phase = 0;
        end else begin
            automatic logic [63:0] old_cnt = m_cnt;
            if (m_pend == 2'b11) begin
                m_cnt = {m_ldhi, m_ldlo};
                m_phase = 0;
            end else if (m_phase >= int'(m_div)) begin
                m_cnt = m_cnt + 64'd1;
                m_phase = 0;
            end else begin
                m_phase++;
            end
            if (m_pend == 2'b01) m_held = old_cnt;
            m_pend = 2'b00;
            if (reg_wr) begin
                case (reg_addr)
                    8'h68: begin
                        m_div = reg_wdata[15:8];
                        if (reg_wdata[0]) m_pend = reg_wdata[1] ? 2'b11 : 2'b01;
                    end
                    8'h74: m_ldlo = reg_wdata;
                    8'h78: m_ldhi = reg_wdata;
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [31:0] m_read(logic [7:0] a);
        case (a)
            8'h68: return {16'h0, m_div, 6'h0, m_pend};
            8'h6C: return m_cnt[31:0];
            8'h70: return m_cnt[63:32];
            8'h74: return m_ldlo;
            8'h78: return m_ldhi;
            8'h7C: return m_held[31:0];
            8'h80: return m_held[63:32];
            default: return 32'h0;
        endcase
    endfunction

    // Per-clock comparison of the addressed register against the model
    always @(posedge clk) begin
        #3;
        if (rst_n && !done) begin
            n_chk++;
            if (reg_rdata !== m_read(reg_addr)) begin
                n_err++;
                $display("FAIL %s per-clock addr %h actual %h expected %h",
                    (reg_addr == 8'h68) ? "R4" :
                    (reg_addr == 8'h7C || reg_addr == 8'h80) ? "R5" : "R6",
                    reg_addr, reg_rdata, m_read(reg_addr));
            end
        end
    end

    task automatic cyc();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        cyc();
        reg_wr = 1'b0;
    endtask

    task automatic chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
        reg_addr = a; #1;
        n_chk++;
        if (reg_rdata !== exp) begin
            n_err++;
            $display("FAIL %s addr %h actual %h expected %h", tag, a, reg_rdata, exp);
        end
    endtask

    task automatic peek(input logic [7:0] a, output logic [31:0] v);
        reg_addr = a; #1; v = reg_rdata;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] s_lo, s_hi, v;
        repeat (3) cyc();
        rst_n = 1'b1;
        // R1 reset state
        chk(8'h68, 32'h0, "R1"); chk(8'h6C, 32'h0, "R1"); chk(8'h70, 32'h0, "R1");
        chk(8'h74, 32'h0, "R1"); chk(8'h7C, 32'h0, "R1"); chk(8'h80, 32'h0, "R1");

        // R3 / R9 load with divider 0
        wr(8'h74, 32'h0000_0010);
        wr(8'h78, 32'h0000_0005);
        wr(8'h68, 32'h0000_0003);
        chk(8'h68, 32'h3, "R4");
        cyc();
        chk(8'h6C, 32'h10, "R9"); chk(8'h70, 32'h5, "R3");
        cyc();
        chk(8'h6C, 32'h11, "R3"); chk(8'h68, 32'h0, "R4");

        // R2 capture
        wr(8'h68, 32'h0000_0001);
        chk(8'h68, 32'h1, "R4");
        peek(8'h6C, s_lo); peek(8'h70, s_hi);
        cyc();
        chk(8'h80, s_hi, "R2");
        cyc();
        chk(8'h7C, s_lo, "R2");
        repeat (5) cyc();
        chk(8'h80, s_hi, "R5"); chk(8'h7C, s_lo, "R5");

        // R8 ignored writes
        wr(8'h7C, 32'hDEAD_BEEF);
        chk(8'h7C, s_lo, "R8");
        peek(8'h6C, v);
        wr(8'h6C, 32'h0);
        chk(8'h6C, v + 32'd1, "R8");
        peek(8'h6C, v);
        wr(8'h68, 32'h0000_0002);
        cyc();
        chk(8'h6C, v + 32'd2, "R8"); chk(8'h68, 32'h0, "R8");
        chk(8'h80, s_hi, "R8");

        // R6 divider 3
        wr(8'h68, 32'h0000_0300);
        chk(8'h68, 32'h300, "R4");
        peek(8'h6C, v);
        repeat (4) cyc();
        chk(8'h6C, v + 32'd1, "R6");
        repeat (8) cyc();
        chk(8'h6C, v + 32'd3, "R6");

        // R9 load under divider, field persists
        wr(8'h74, 32'h0000_0077);
        wr(8'h78, 32'h0);
        wr(8'h68, 32'h0000_0303);
        cyc();
        chk(8'h6C, 32'h77, "R9"); chk(8'h70, 32'h0, "R9");
        chk(8'h68, 32'h300, "R4");
        chk(8'h7C, s_lo, "R5");

        // R7 wrap
        wr(8'h68, 32'h0);
        wr(8'h74, 32'hFFFF_FFFE);
        wr(8'h78, 32'hFFFF_FFFF);
        wr(8'h68, 32'h3);
        cyc();
        chk(8'h6C, 32'hFFFF_FFFE, "R7"); chk(8'h70, 32'hFFFF_FFFF, "R7");
        cyc();
        chk(8'h6C, 32'hFFFF_FFFF, "R7");
        cyc();
        chk(8'h6C, 32'h0, "R7"); chk(8'h70, 32'h0, "R7");

        repeat (3) cyc();
        finish_run();
    end

endmodule